// File: doc/BRIEF.md
# IP and L4 Header Exception Classifier

This block inspects a received packet presented one byte per beat, starting at the first byte of the IP header. Each beat carries a valid strobe, a last-beat marker and a sideband carrying the total byte count of the frame. The byte count is sampled on the first beat of each frame. The block captures the IPv4 or IPv6 fixed-header fields and the leading bytes of a TCP or UDP header. It accumulates the IPv4 header checksum as the bytes go by. On the final beat it classifies the frame.

One cycle after the last beat, the block presents a single registered result, qualified by a one-cycle valid pulse. The result holds five flags (IPv6, fragment, TCP-or-UDP, IP exception, L4 error) and an 8-bit error code. IP-level faults are ranked by their code number. Transport-level faults are only considered for whole, exception-free, non-fragmented TCP or UDP packets. The next frame may start on the beat right after a last beat.

Top module: `ipl4_exc_classifier`

## Requirements
- R1: A beat with `in_valid` and `in_last` high produces exactly one `res_valid` pulse on the following clock cycle, and no pulse occurs otherwise. A new frame may begin on the very next beat, with no idle cycle.
- R2: If the upper nibble of byte 0 is neither 4 nor 6, the result sets the IP exception flag with code 1. In that case the fragment and TCP-or-UDP flags stay clear.
- R3: The header length is 4 times the lower nibble of byte 0 for IPv4, and 40 for IPv6. If the sampled frame byte count is below the header length, or an IPv4 header-length nibble is below 5, the result is an IP exception with code 3. The fragment and TCP-or-UDP flags then stay clear.
- R4: For a complete IPv4 header, the header bytes are summed as big-endian 16-bit words in ones'-complement arithmetic. If that sum is not 0xFFFF, the result is an IP exception with code 2.
- R5: The stated length is bytes 2-3 for IPv4, and 40 plus bytes 4-5 for IPv6. A frame byte count below the stated length gives an IP exception with code 4. Bytes beyond the stated length are accepted without error.
- R6: A zero hop count (IPv4 byte 8, IPv6 byte 7) gives code 5, and an IPv4 header-length nibble above 5 gives code 6. When several IP conditions hold, the lowest code is reported.
- R7: The fragment flag is set for IPv4 when byte 6 bit 5 is set or the 13-bit offset (bytes 6-7, low 13 bits) is nonzero. For IPv6 it is set when byte 6 equals 44. A fragment never reports an L4 error.
- R8: The protocol is IPv4 byte 9 or IPv6 byte 6. The TCP-or-UDP flag is set for protocol 6 or 17 on a valid, complete header. Any other protocol runs no L4 check. The IPv6 flag reflects a version nibble of 6.
- R9: L4 bytes start at the header length, and the L4 space is the stated length minus the header length. If this space is below 20 bytes for TCP or 8 bytes for UDP, the L4 error flag is set with code 1.
- R10: If the UDP length field (L4 bytes 4-5) exceeds the L4 space, the result is L4 error code 3.
- R11: A zero source port (L4 bytes 0-1) or destination port (L4 bytes 2-3) gives L4 error code 4.
- R12: TCP flags are read from L4 byte 13, with FIN at bit 0, SYN at bit 1, RST at bit 2 and URG at bit 5. Looking at bits 5:0 only:
  - FIN alone gives code 8.
  - No flags set gives code 9.
  - FIN with RST gives code 10.
  - SYN with URG gives code 11.
  - SYN with RST gives code 12.
  - SYN with FIN gives code 13.
  
  When several flag conditions apply, the lowest code is reported. Across L4 checks the order of precedence is code 1, then 3, then 4, then the flag codes.
- R13: A frame with no IP exception and no L4 error reports code 0 with both error flags clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte beat qualifier |
| in_data | input | 8 | Packet byte, IP header first |
| in_last | input | 1 | Marks the final byte of the frame |
| frame_len | input | 16 | Total frame byte count, sampled on the first beat |
| res_valid | output | 1 | One-cycle result qualifier |
| res_is_v6 | output | 1 | Packet is IPv6 |
| res_frag | output | 1 | Packet is a fragment |
| res_l4 | output | 1 | Protocol is TCP or UDP |
| res_ip_exc | output | 1 | IP-level exception detected |
| res_l4_err | output | 1 | L4-level error detected |
| res_code | output | 8 | Error code, 0 when clean |

## Verification
The bench goes after code precedence:
- A bad checksum together with a zero TTL must report 2. A design that checked TTL first would report 5.
- A short TCP segment with zero ports must report 1, not 4.
- A zero source port combined with FIN alone must report 4 rather than 8.
- FIN+RST+SYN must report 10. A design whose flag chain was ordered wrongly would report 12 or 13.

It also checks that fragments and non-TCP/UDP protocols suppress L4 errors, and that trailing pad beyond the stated length is accepted. A design that mixed up pad with truncation would raise code 4 on the padded frame. Frames are sent back to back and with gaps, and the result cycle is checked exactly. A parser that needed an idle cycle would drop or corrupt the following result.

// File: rtl/ipx_pkg.sv
package ipx_pkg;

    localparam int LEN_W  = 16;
    localparam int SUM_W  = 24;
    localparam int CODE_W = 8;

    localparam logic [7:0] PROTO_TCP  = 8'd6;
    localparam logic [7:0] PROTO_UDP  = 8'd17;
    localparam logic [7:0] NH_FRAG    = 8'd44;
    localparam logic [16:0] V6_HDR    = 17'd40;
    localparam logic [16:0] TCP_MIN   = 17'd20;
    localparam logic [16:0] UDP_MIN   = 17'd8;

    typedef struct packed {
        logic [3:0]       ver;
        logic [3:0]       ihl;
        logic [LEN_W-1:0] len;
        logic [15:0]      fraginfo;
        logic [7:0]       hop;
        logic [7:0]       proto;
        logic [SUM_W-1:0] csum;
        logic [15:0]      sport;
        logic [15:0]      dport;
        logic [15:0]      ulen;
        logic [7:0]       tflags;
        logic [LEN_W-1:0] flen;
    } hdr_t;

    typedef struct packed {
        logic              is_v6;
        logic              frag;
        logic              l4;
        logic              ip_exc;
        logic              l4_err;
        logic [CODE_W-1:0] code;
    } res_t;

    function automatic logic [CODE_W-1:0] tcp_flag_code(logic [7:0] f);
        logic [CODE_W-1:0] c;
        c = '0;
        if (f[5:0] == 6'b000001)      c = 8'd8;
        else if (f[5:0] == 6'b000000) c = 8'd9;
        else if (f[0] && f[2])        c = 8'd10;
        else if (f[1] && f[5])        c = 8'd11;
        else if (f[1] && f[2])        c = 8'd12;
        else if (f[1] && f[0])        c = 8'd13;
        return c;
    endfunction

    function automatic res_t classify(hdr_t h);
        res_t              r;
        logic              v4, v6, hdr_ok, csum_ok, parsed, tcp, udp;
        logic [16:0]       hlen, stated, avail, need;
        logic [16:0]       s1;
        logic [15:0]       s2;
        logic [CODE_W-1:0] ipc, l4c;
        r      = '0;
        v4     = (h.ver == 4'd4);
        v6     = (h.ver == 4'd6);
        hlen   = v4 ? {11'd0, h.ihl, 2'b00} : V6_HDR;
        stated = v4 ? {1'b0, h.len} : ({1'b0, h.len} + V6_HDR);
        hdr_ok = ({1'b0, h.flen} >= hlen) && !(v4 && (h.ihl < 4'd5));
        s1     = {1'b0, h.csum[15:0]} + {9'd0, h.csum[23:16]};
        s2     = s1[15:0] + {15'd0, s1[16]};
        csum_ok = (s2 == 16'hFFFF);
        ipc = '0;
        if (!(v4 || v6))                     ipc = 8'd1;
        else if (!hdr_ok)                    ipc = 8'd3;
        else if (v4 && !csum_ok)             ipc = 8'd2;
        else if ({1'b0, h.flen} < stated)    ipc = 8'd4;
        else if (h.hop == 8'd0)              ipc = 8'd5;
        else if (v4 && (h.ihl > 4'd5))       ipc = 8'd6;
        parsed   = (v4 || v6) && hdr_ok;
        r.is_v6  = v6;
        r.ip_exc = (ipc != '0);
        r.frag   = parsed && (v4 ? (h.fraginfo[13] || (h.fraginfo[12:0] != 13'd0))
                                 : (h.proto == NH_FRAG));
        tcp      = parsed && (h.proto == PROTO_TCP);
        udp      = parsed && (h.proto == PROTO_UDP);
        r.l4     = tcp || udp;
        avail    = (stated > hlen) ? (stated - hlen) : 17'd0;
        need     = tcp ? TCP_MIN : UDP_MIN;
        l4c = '0;
        if (!r.ip_exc && !r.frag && r.l4) begin
            if (avail < need)                              l4c = 8'd1;
            else if (udp && ({1'b0, h.ulen} > avail))      l4c = 8'd3;
            else if ((h.sport == 16'd0) || (h.dport == 16'd0)) l4c = 8'd4;
            else if (tcp)                                  l4c = tcp_flag_code(h.tflags);
        end
        r.l4_err = (l4c != '0);
        r.code   = r.ip_exc ? ipc : l4c;
        return r;
    endfunction

endpackage

// File: rtl/ipx_hdr_capture.sv
module ipx_hdr_capture
    import ipx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    input  logic [LEN_W-1:0] frame_len,
    output hdr_t             hdr_nxt,
    output logic             fire
);
    localparam logic [LEN_W-1:0] IDX_MAX = '1;

    logic [LEN_W-1:0] idx_q;
    hdr_t             hdr_q;
    hdr_t             h;
    logic [LEN_W-1:0] l4off;
    logic [LEN_W-1:0] rel;
    logic [LEN_W-1:0] v4hlen;
    logic             sof;

    assign sof = (idx_q == '0);

    always_comb begin
        h      = sof ? '0 : hdr_q;
        l4off  = '0;
        rel    = '0;
        v4hlen = '0;
        if (in_valid) begin
            if (sof) begin
                h.flen = frame_len;
                h.ver  = in_data[7:4];
                h.ihl  = in_data[3:0];
            end
            v4hlen = {{(LEN_W-6){1'b0}}, h.ihl, 2'b00};
            if (h.ver == 4'd4) begin
                case (idx_q)
                    16'd2, 16'd3: h.len      = {h.len[7:0], in_data};
                    16'd6, 16'd7: h.fraginfo = {h.fraginfo[7:0], in_data};
                    16'd8:        h.hop      = in_data;
                    16'd9:        h.proto    = in_data;
                    default: ;
                endcase
                if (idx_q < v4hlen)
                    h.csum = h.csum + (idx_q[0] ? {16'd0, in_data} : {8'd0, in_data, 8'd0});
            end else if (h.ver == 4'd6) begin
                case (idx_q)
                    16'd4, 16'd5: h.len   = {h.len[7:0], in_data};
                    16'd6:        h.proto = in_data;
                    16'd7:        h.hop   = in_data;
                    default: ;
                endcase
            end
            l4off = (h.ver == 4'd4) ? v4hlen : 16'd40;
            if ((idx_q >= 16'd20) && (idx_q >= l4off)) begin
                rel = idx_q - l4off;
                case (rel)
                    16'd0, 16'd1: h.sport  = {h.sport[7:0], in_data};
                    16'd2, 16'd3: h.dport  = {h.dport[7:0], in_data};
                    16'd4, 16'd5: h.ulen   = {h.ulen[7:0], in_data};
                    16'd13:       h.tflags = in_data;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            hdr_q <= '0;
        end else if (in_valid) begin
            hdr_q <= h;
            if (in_last)             idx_q <= '0;
            else if (idx_q != IDX_MAX) idx_q <= idx_q + 1'b1;
        end
    end

    assign hdr_nxt = h;
    assign fire    = in_valid && in_last;

endmodule

// File: rtl/ipx_classify.sv
module ipx_classify
    import ipx_pkg::*;
(
    input  hdr_t hdr,
    output res_t res
);
    always_comb res = classify(hdr);
endmodule

// File: rtl/ipl4_exc_classifier.sv
module ipl4_exc_classifier
    import ipx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    input  logic [LEN_W-1:0] frame_len,
    output logic             res_valid,
    output logic             res_is_v6,
    output logic             res_frag,
    output logic             res_l4,
    output logic             res_ip_exc,
    output logic             res_l4_err,
    output logic [CODE_W-1:0] res_code
);
    hdr_t hdr_nxt;
    logic fire;
    res_t res_c;
    res_t res_q;
    logic vld_q;

    ipx_hdr_capture u_cap (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_last   (in_last),
        .frame_len (frame_len),
        .hdr_nxt   (hdr_nxt),
        .fire      (fire)
    );

    ipx_classify u_cls (
        .hdr (hdr_nxt),
        .res (res_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= fire;
            if (fire) res_q <= res_c;
        end
    end

    assign res_valid  = vld_q;
    assign res_is_v6  = res_q.is_v6;
    assign res_frag   = res_q.frag;
    assign res_l4     = res_q.l4;
    assign res_ip_exc = res_q.ip_exc;
    assign res_l4_err = res_q.l4_err;
    assign res_code   = res_q.code;

endmodule

// File: rtl/ipx_exc_checker.sv
module ipx_exc_checker (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_last,
    input logic       res_valid,
    input logic       res_frag,
    input logic       res_l4,
    input logic       res_ip_exc,
    input logic       res_l4_err,
    input logic [7:0] res_code
);
    AST_PULSE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_last) |=> res_valid); // R1

    AST_PULSE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(in_valid && in_last)); // R1

    AST_IP_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_ip_exc) |-> (res_code >= 8'd1 && res_code <= 8'd6 && !res_l4_err)); // R6

    AST_L4_GATED: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_l4_err) |-> (res_l4 && !res_frag && !res_ip_exc)); // R7

    AST_L4_CODE_SET: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_l4_err) |-> (res_code == 8'd1 || res_code == 8'd3 || res_code == 8'd4
                                       || (res_code >= 8'd8 && res_code <= 8'd13))); // R12

    AST_CLEAN_ZERO: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ip_exc && !res_l4_err) |-> (res_code == 8'd0)); // R13
endmodule

bind ipl4_exc_classifier ipx_exc_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_last    (in_last),
    .res_valid  (res_valid),
    .res_frag   (res_frag),
    .res_l4     (res_l4),
    .res_ip_exc (res_ip_exc),
    .res_l4_err (res_l4_err),
    .res_code   (res_code)
);

// File: tb/ipl4_exc_classifier_tb.sv
module ipl4_exc_classifier_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic [15:0] frame_len = '0;
    logic        res_valid, res_is_v6, res_frag, res_l4, res_ip_exc, res_l4_err;
    logic [7:0]  res_code;

    always #2 clk = ~clk;

    ipl4_exc_classifier u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .frame_len(frame_len), .res_valid(res_valid),
        .res_is_v6(res_is_v6), .res_frag(res_frag), .res_l4(res_l4),
        .res_ip_exc(res_ip_exc), .res_l4_err(res_l4_err), .res_code(res_code)
    );

    typedef struct {
        logic [12:0] v;
        string       tag;
    } exp_t;

    exp_t       exp_q[$];
    int         due_q[$];
    logic [7:0] pkt[$];
    int         checks = 0;
    int         errors = 0;
    int         cyc = 0;
    bit         done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            logic [12:0] got;
            got = {res_is_v6, res_frag, res_l4, res_ip_exc, res_l4_err, res_code};
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R1 unexpected result actual=%h expected=none", got);
            end else begin
                exp_t e;
                int   d;
                e = exp_q.pop_front();
                d = due_q.pop_front();
                if (got !== e.v) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", e.tag, got, e.v);
                end
                checks++;
                if (cyc != d) begin
                    errors++;
                    $display("FAIL R1 result cycle actual=%0d expected=%0d", cyc, d);
                end
            end
        end
    end

    task automatic expect_res(bit v6, bit fr, bit l4, bit ie, bit le, int code, string tag);
        exp_t e;
        e.v   = {v6, fr, l4, ie, le, 8'(code)};
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic v4_hdr(int ihl, int tot, int fragw, int ttl, int proto, bit bad);
        int base;
        int sum;
        base = pkt.size();
        pkt.push_back(8'(8'h40 | ihl));
        pkt.push_back(8'h00);
        pkt.push_back(8'(tot >> 8));
        pkt.push_back(8'(tot));
        pkt.push_back(8'h12);
        pkt.push_back(8'h34);
        pkt.push_back(8'(fragw >> 8));
        pkt.push_back(8'(fragw));
        pkt.push_back(8'(ttl));
        pkt.push_back(8'(proto));
        pkt.push_back(8'h00);
        pkt.push_back(8'h00);
        for (int i = 0; i < 8; i++) pkt.push_back(8'(8'h0A + i));
        for (int i = 0; i < (ihl - 5) * 4; i++) pkt.push_back(8'h01);
        sum = 0;
        for (int i = 0; i < ihl * 4; i += 2)
            sum += {pkt[base + i], pkt[base + i + 1]};
        while (sum > 32'hFFFF) sum = (sum & 32'hFFFF) + (sum >> 16);
        sum = ~sum & 32'hFFFF;
        pkt[base + 10] = 8'(sum >> 8);
        pkt[base + 11] = bad ? 8'(sum ^ 1) : 8'(sum);
    endtask

    task automatic v6_hdr(int plen, int nh, int hop);
        pkt.push_back(8'h60);
        pkt.push_back(8'h00);
        pkt.push_back(8'h00);
        pkt.push_back(8'h00);
        pkt.push_back(8'(plen >> 8));
        pkt.push_back(8'(plen));
        pkt.push_back(8'(nh));
        pkt.push_back(8'(hop));
        for (int i = 0; i < 32; i++) pkt.push_back(8'(8'h20 + i));
    endtask

    task automatic tcp_hdr(int sp, int dp, int flags);
        pkt.push_back(8'(sp >> 8)); pkt.push_back(8'(sp));
        pkt.push_back(8'(dp >> 8)); pkt.push_back(8'(dp));
        for (int i = 0; i < 8; i++) pkt.push_back(8'h00);
        pkt.push_back(8'h50);
        pkt.push_back(8'(flags));
        for (int i = 0; i < 6; i++) pkt.push_back(8'h00);
    endtask

    task automatic udp_hdr(int sp, int dp, int ulen);
        pkt.push_back(8'(sp >> 8)); pkt.push_back(8'(sp));
        pkt.push_back(8'(dp >> 8)); pkt.push_back(8'(dp));
        pkt.push_back(8'(ulen >> 8)); pkt.push_back(8'(ulen));
        pkt.push_back(8'h00); pkt.push_back(8'h00);
    endtask

    task automatic cut(int n);
        while (pkt.size() > n) void'(pkt.pop_back());
    endtask

    task automatic send(int gap);
        int n;
        n = pkt.size();
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid  = 1'b1;
            in_data   = pkt[i];
            in_last   = (i == n - 1);
            frame_len = 16'(n);
            if (i == n - 1) due_q.push_back(cyc + 1);
        end
        pkt.delete();
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_last  = 1'b0;
        end
    endtask

    task automatic tcp_flag_case(int flags, int code, string tag);
        v4_hdr(5, 40, 0, 64, 6, 0); tcp_hdr(1000, 2000, flags);
        expect_res(0, 0, 1, 0, code != 0, code, tag);
        send(0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (res_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset res_valid actual=%b expected=0", res_valid);
        end
        rst = 1'b0;
        @(negedge clk);

        // R13 clean TCP and UDP, back to back
        v4_hdr(5, 40, 0, 64, 6, 0); tcp_hdr(1234, 80, 8'h10);
        expect_res(0, 0, 1, 0, 0, 0, "R13 clean v4 tcp"); send(0);
        v4_hdr(5, 28, 0, 64, 17, 0); udp_hdr(53, 5353, 8);
        expect_res(0, 0, 1, 0, 0, 0, "R13 clean v4 udp"); send(2);
        // R2 bad version
        v4_hdr(5, 40, 0, 64, 6, 0); tcp_hdr(1, 2, 8'h10); pkt[0] = 8'h55;
        expect_res(0, 0, 0, 1, 0, 1, "R2 not ip"); send(0);
        // R3 truncated header
        v4_hdr(5, 40, 0, 64, 6, 0); cut(12);
        expect_res(0, 0, 0, 1, 0, 3, "R3 short header"); send(0);
        // R4 checksum, R6 precedence over ttl zero
        v4_hdr(5, 40, 0, 64, 6, 1); tcp_hdr(1, 2, 8'h10);
        expect_res(0, 0, 1, 1, 0, 2, "R4 bad checksum"); send(1);
        v4_hdr(5, 40, 0, 0, 6, 1); tcp_hdr(1, 2, 8'h10);
        expect_res(0, 0, 1, 1, 0, 2, "R6 lowest code csum+ttl"); send(0);
        // R5 short frame, pad allowed
        v4_hdr(5, 60, 0, 64, 6, 0); tcp_hdr(1, 2, 8'h10);
        expect_res(0, 0, 1, 1, 0, 4, "R5 short frame"); send(0);
        v4_hdr(5, 28, 0, 64, 17, 0); udp_hdr(7, 9, 8);
        for (int i = 0; i < 10; i++) pkt.push_back(8'hEE);
        expect_res(0, 0, 1, 0, 0, 0, "R5 pad accepted"); send(0);
        // R6 ttl zero, options, v6 hop zero
        v4_hdr(5, 40, 0, 0, 6, 0); tcp_hdr(1, 2, 8'h10);
        expect_res(0, 0, 1, 1, 0, 5, "R6 ttl zero"); send(0);
        v4_hdr(6, 44, 0, 64, 6, 0); tcp_hdr(1, 2, 8'h10);
        expect_res(0, 0, 1, 1, 0, 6, "R6 options"); send(0);
        v6_hdr(8, 17, 0); udp_hdr(1, 2, 8);
        expect_res(1, 0, 1, 1, 0, 5, "R6 v6 hop zero"); send(0);
        // R7 fragments
        v4_hdr(5, 40, 16'h2000, 64, 6, 0); tcp_hdr(1, 2, 0);
        expect_res(0, 1, 1, 0, 0, 0, "R7 v4 more-fragments"); send(0);
        v4_hdr(5, 20, 16'h0010, 64, 17, 0);
        expect_res(0, 1, 1, 0, 0, 0, "R7 v4 offset"); send(0);
        v6_hdr(0, 44, 64);
        expect_res(1, 1, 0, 0, 0, 0, "R7 v6 next header 44"); send(3);
        // R8 v6 udp, other protocol
        v6_hdr(8, 17, 64); udp_hdr(1, 2, 8);
        expect_res(1, 0, 1, 0, 0, 0, "R8 v6 udp"); send(0);
        v4_hdr(5, 28, 0, 64, 1, 0); for (int i = 0; i < 8; i++) pkt.push_back(8'h00);
        expect_res(0, 0, 0, 0, 0, 0, "R8 other protocol"); send(0);
        // R9 malformed beats zero ports
        v4_hdr(5, 30, 0, 64, 6, 0); tcp_hdr(0, 0, 0); cut(30);
        expect_res(0, 0, 1, 0, 1, 1, "R9 malformed tcp"); send(0);
        // R10 udp length
        v4_hdr(5, 28, 0, 64, 17, 0); udp_hdr(0, 9, 20);
        expect_res(0, 0, 1, 0, 1, 3, "R10 udp length over"); send(0);
        // R11 zero ports
        v4_hdr(5, 28, 0, 64, 17, 0); udp_hdr(7, 0, 8);
        expect_res(0, 0, 1, 0, 1, 4, "R11 udp dport zero"); send(0);
        v4_hdr(5, 40, 0, 64, 6, 0); tcp_hdr(0, 80, 8'h01);
        expect_res(0, 0, 1, 0, 1, 4, "R11 port beats flags"); send(0);
        // R12 flag codes
        tcp_flag_case(8'h01,  8, "R12 fin only");
        tcp_flag_case(8'h00,  9, "R12 no flags");
        tcp_flag_case(8'h05, 10, "R12 fin rst");
        tcp_flag_case(8'h22, 11, "R12 syn urg");
        tcp_flag_case(8'h06, 12, "R12 syn rst");
        tcp_flag_case(8'h03, 13, "R12 syn fin");
        tcp_flag_case(8'h07, 10, "R12 lowest flag code");
        tcp_flag_case(8'h02,  0, "R12 syn alone clean");
        tcp_flag_case(8'h11,  0, "R12 ack fin clean");

        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        repeat (5) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R1 missing results actual=%0d expected=0", exp_q.size());
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule